// File: doc/BRIEF.md
# Keyed Configuration Item Port

This block gives a host a programmed-I/O window onto a fixed table of configuration items. The host first writes a 16-bit key to pick an item, then pulls the item's bytes out through a data register. Each read returns the next bytes of the item and moves an internal cursor forward, so the item comes out as a byte stream rather than as addressed registers. One access may ask for 1 to 8 bytes. The bytes are packed most-significant-first into the low end of the result, and zeros fill the tail once the item runs out.

The key holds a bank flag and an item index. The flag chooses one of two item banks, one common and one local to the architecture. Index values past the table size leave the port in an invalid state that returns only zeros. Two host framings are supported and chosen by a strap. In the single-register framing, byte accesses move data and 16-bit writes select. In the split framing, a control register takes only 16-bit writes and a data register sits at offset 0. Data writes are accepted and dropped. Every access gets one response exactly one cycle later, and a framing violation is flagged as an error.

Top module: `cfg_item_port`

## Requirements
- R1: After reset the selected key is 0 (common bank, index 0) and the cursor is 0, so the first data read returns that item's leading bytes.
- R2: Every accepted select sets the cursor to 0, and this includes selecting the key that is already current.
- R3: Key bit 15 set chooses the local bank, and bits 14:0 are the index. An index of 12 or more makes the selection invalid, and later reads of it return zero.
- R4: A read of N bytes (1 to 8) places item bytes cursor..cursor+N-1 with the first byte in bits [8N-1:8N-8] of resp_data, leaves the bits above 8N at zero, and advances the cursor by N.
- R5: When fewer than N bytes remain, only the remaining bytes are returned, followed by zero bytes at the low end, and the cursor stops at the item length.
- R6: A read of an invalid selection, an empty item, or a cursor at or past the length returns zero and leaves the cursor unchanged.
- R7: With port_mode=1, a 1-byte read is a data read, a 1-byte write is a data write, and a 2-byte write selects the key wdata[15:0]. Every other access is rejected: resp_err=1, resp_data=0, and no state changes.
- R8: With port_mode=0, acc_sel=0 is the control register and accepts only 2-byte writes, which select the key wdata[15:0]. acc_sel=1 is the data register and accepts sizes 1 to 8, only at acc_offset 0. Every other access is rejected as in R7.
- R9: An accepted data write gives resp_err=0 and resp_data=0 and leaves the cursor and selection unchanged.
- R10: resp_valid is high in the cycle after each access strobe and low otherwise. resp_data and resp_err belong to that access.
- R11: Item (bank b, index i) has a length of (3i+4) mod 17 for b=0 and (5i) mod 17 for b=1. Its byte at offset o is (16i + o + 128b) mod 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_mode | input | 1 | 1 = single-register framing, 0 = split control/data framing |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 1 | Split framing: 0 = control register, 1 = data register; ignored otherwise |
| acc_offset | input | 3 | Byte offset inside the addressed register |
| acc_size | input | 4 | Access width in bytes |
| acc_wdata | input | 64 | Write data; the key is taken from bits 15:0 |
| resp_valid | output | 1 | Response strobe, one cycle after acc_valid |
| resp_err | output | 1 | Access rejected by the framing rules |
| resp_data | output | 64 | Read result, right-justified; zero for writes and rejects |

## Verification
The bench works through the points where a stream port usually breaks. These are a wide read that crosses the end of an item, where a faulty design would shift the padding to the wrong side or let the cursor overrun the length, and the reads that follow, which must stay zero. Out-of-range and empty items are selected in both banks, and one design that mixed up the bank flag with the index returns the other bank's bytes. Reselecting the current key has to restart the stream. Framing violations in both framings must be flagged without touching the cursor, and dropped data writes must not advance it. A sweep over every index in both banks, plus two past the table end, compares lengths and bytes against the formulas.

// File: rtl/cfgp_pkg.sv
// Package cfgp_pkg
// Shared types for the keyed configuration item port.
// Assumes: one access per cycle at most, decoded into a single kind.
package cfgp_pkg;

    // Class of a host access after the framing rules are applied
    typedef enum logic [1:0] {
        ACC_REJECT = 2'd0,
        ACC_SELECT = 2'd1,
        ACC_READ   = 2'd2,
        ACC_DROP   = 2'd3
    } acc_kind_e;

endpackage

// File: rtl/cfgp_decode.sv
// Module cfgp_decode
// Classifies a host access as select, data read, dropped data write or
// reject, under either the single-register or the split framing.
// Assumes: acc_size is the byte count; clk/rst_n serve only the checks.
module cfgp_decode
    import cfgp_pkg::*;
#(
    parameter int LANES = 8,
    parameter int SZ_W  = $clog2(LANES + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            port_mode,
    input  logic            acc_valid,
    input  logic            acc_write,
    input  logic            acc_sel,
    input  logic [2:0]      acc_offset,
    input  logic [SZ_W-1:0] acc_size,
    output acc_kind_e       kind
);

    localparam logic [SZ_W-1:0] SZ_ONE = SZ_W'(1);
    localparam logic [SZ_W-1:0] SZ_TWO = SZ_W'(2);
    localparam logic [SZ_W-1:0] SZ_MAX = SZ_W'(LANES);

    logic data_size_ok;

    // Apply the framing rules to pick the access kind
    always_comb begin
        data_size_ok = (acc_size >= SZ_ONE) && (acc_size <= SZ_MAX);
        kind = ACC_REJECT;
        if (port_mode) begin
            if (acc_size == SZ_ONE)
                kind = acc_write ? ACC_DROP : ACC_READ;
            else if (acc_size == SZ_TWO && acc_write)
                kind = ACC_SELECT;
        end else if (!acc_sel) begin
            if (acc_write && acc_size == SZ_TWO)
                kind = ACC_SELECT;
        end else if (acc_offset == 3'd0 && data_size_ok) begin
            kind = acc_write ? ACC_DROP : ACC_READ;
        end
    end

    AST_COMB_BYTE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && port_mode && (kind == ACC_READ || kind == ACC_DROP)) |-> (acc_size == SZ_ONE)); // R7
    AST_CTL_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !port_mode && !acc_sel && kind != ACC_REJECT) |-> (acc_write && acc_size == SZ_TWO)); // R8

endmodule

// File: rtl/cfgp_bank.sv
// Module cfgp_bank
// Preloaded item store for one bank: returns the length of the indexed
// item and the LANES bytes that start at the given offset.
// Assumes: contents are fixed at build time and computed from the index.
module cfgp_bank #(
    parameter int SLOT_BYTES = 16,
    parameter int LANES      = 8,
    parameter int IDX_W      = 15,
    parameter int OFF_W      = 32,
    parameter int LEN_MUL    = 3,
    parameter int LEN_ADD    = 4,
    parameter int BYTE_BASE  = 0
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [OFF_W-1:0] off,
    output logic [OFF_W-1:0] len,
    output logic [7:0]       lanes [LANES]
);

    localparam int LEN_MOD = SLOT_BYTES + 1;

    logic [31:0] idx_w;

    // Length table entry for the indexed item
    always_comb begin
        idx_w = 32'(idx);
        len   = OFF_W'((idx_w * 32'(LEN_MUL) + 32'(LEN_ADD)) % 32'(LEN_MOD));
    end

    // One byte lane per position of the widest access
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lanes[k] = 8'(idx_w * 32'(SLOT_BYTES) + 32'(off) + 32'(k) + 32'(BYTE_BASE));
    end

endmodule

// File: rtl/cfgp_cursor.sv
// Module cfgp_cursor
// Holds the selected key, its validity and the read cursor; packs the
// bytes of a data read big-endian with zero fill past the item end.
// Assumes: sel_fire and rd_fire are never high together.
module cfgp_cursor #(
    parameter int KEY_W     = 16,
    parameter int LOCAL_BIT = 15,
    parameter int MAX_ENTRY = 12,
    parameter int LANES     = 8,
    parameter int OFF_W     = 32,
    parameter int SZ_W      = $clog2(LANES + 1),
    parameter int DATA_W    = 8 * LANES,
    parameter int IDX_W     = LOCAL_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_fire,
    input  logic [KEY_W-1:0]  sel_key,
    input  logic              rd_fire,
    input  logic [SZ_W-1:0]   rd_size,
    input  logic [OFF_W-1:0]  item_len,
    input  logic [7:0]        lanes [LANES],
    output logic              cur_bank,
    output logic [IDX_W-1:0]  cur_idx,
    output logic [OFF_W-1:0]  cur_off,
    output logic [DATA_W-1:0] rd_word
);

    logic [KEY_W-1:0] cur_key;
    logic             cur_valid;
    logic             live;
    logic [OFF_W-1:0] avail;
    logic [SZ_W-1:0]  take;

    assign cur_bank = cur_key[LOCAL_BIT];
    assign cur_idx  = cur_key[IDX_W-1:0];

    // Count the bytes this read consumes and pack them MSB-first
    always_comb begin
        live  = cur_valid && (cur_off < item_len);
        avail = item_len - cur_off;
        take  = (OFF_W'(rd_size) < avail) ? rd_size : SZ_W'(avail);
        if (!live)
            take = '0;
        rd_word = '0;
        for (int k = 0; k < LANES; k++) begin
            if (k < int'(take))
                rd_word = rd_word | (DATA_W'(lanes[k]) << (8 * (int'(rd_size) - 1 - k)));
        end
    end

    // Key, validity and cursor registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_key   <= '0;
            cur_valid <= 1'b1;
            cur_off   <= '0;
        end else if (sel_fire) begin
            cur_key   <= sel_key;
            cur_valid <= (32'(sel_key[IDX_W-1:0]) < 32'(MAX_ENTRY));
            cur_off   <= '0;
        end else if (rd_fire) begin
            cur_off   <= cur_off + OFF_W'(take);
        end
    end

    AST_SEL_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        sel_fire |=> (cur_off == '0)); // R2
    AST_OFF_IN_ITEM: assert property (@(posedge clk) disable iff (!rst_n)
        cur_valid |-> (cur_off <= item_len)); // R5
    AST_INVALID_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur_valid && !sel_fire) |=> $stable(cur_off)); // R6
    AST_ADVANCE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fire |=> (cur_off <= $past(cur_off) + OFF_W'($past(rd_size)))); // R4

endmodule

// File: rtl/cfg_item_port.sv
// Module cfg_item_port
// Keyed configuration item port: decodes host accesses, keeps the item
// cursor, reads two preloaded banks and registers one response per access.
// Assumes: synchronous active-low reset; the response follows in one cycle.
module cfg_item_port
    import cfgp_pkg::*;
#(
    parameter int KEY_W      = 16,
    parameter int LOCAL_BIT  = 15,
    parameter int MAX_ENTRY  = 12,
    parameter int SLOT_BYTES = 16,
    parameter int LANES      = 8,
    parameter int OFF_W      = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         port_mode,
    input  logic                         acc_valid,
    input  logic                         acc_write,
    input  logic                         acc_sel,
    input  logic [2:0]                   acc_offset,
    input  logic [$clog2(LANES+1)-1:0]   acc_size,
    input  logic [8*LANES-1:0]           acc_wdata,
    output logic                         resp_valid,
    output logic                         resp_err,
    output logic [8*LANES-1:0]           resp_data
);

    localparam int SZ_W   = $clog2(LANES + 1);
    localparam int DATA_W = 8 * LANES;
    localparam int IDX_W  = LOCAL_BIT;
    localparam int NBANK  = 2;

    acc_kind_e        kind;
    logic             sel_fire;
    logic             rd_fire;
    logic             cur_bank;
    logic [IDX_W-1:0] cur_idx;
    logic [OFF_W-1:0] cur_off;
    logic [DATA_W-1:0] rd_word;
    logic [OFF_W-1:0] bank_len  [NBANK];
    logic [7:0]       bank_lane [NBANK][LANES];
    logic [OFF_W-1:0] item_len;
    logic [7:0]       item_lane [LANES];

    cfgp_decode #(.LANES(LANES), .SZ_W(SZ_W)) u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .port_mode  (port_mode),
        .acc_valid  (acc_valid),
        .acc_write  (acc_write),
        .acc_sel    (acc_sel),
        .acc_offset (acc_offset),
        .acc_size   (acc_size),
        .kind       (kind)
    );

    assign sel_fire = acc_valid && (kind == ACC_SELECT);
    assign rd_fire  = acc_valid && (kind == ACC_READ);

    // Two item banks; the bank parameters pick the preloaded contents
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        cfgp_bank #(
            .SLOT_BYTES (SLOT_BYTES),
            .LANES      (LANES),
            .IDX_W      (IDX_W),
            .OFF_W      (OFF_W),
            .LEN_MUL    ((b == 0) ? 3 : 5),
            .LEN_ADD    ((b == 0) ? 4 : 0),
            .BYTE_BASE  (b * 128)
        ) u_bank (
            .idx   (cur_idx),
            .off   (cur_off),
            .len   (bank_len[b]),
            .lanes (bank_lane[b])
        );
    end

    // Route the selected bank to the cursor
    always_comb begin
        item_len = bank_len[cur_bank];
        for (int k = 0; k < LANES; k++)
            item_lane[k] = bank_lane[cur_bank][k];
    end

    cfgp_cursor #(
        .KEY_W     (KEY_W),
        .LOCAL_BIT (LOCAL_BIT),
        .MAX_ENTRY (MAX_ENTRY),
        .LANES     (LANES),
        .OFF_W     (OFF_W),
        .SZ_W      (SZ_W),
        .DATA_W    (DATA_W),
        .IDX_W     (IDX_W)
    ) u_cursor (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_fire (sel_fire),
        .sel_key  (acc_wdata[KEY_W-1:0]),
        .rd_fire  (rd_fire),
        .rd_size  (acc_size),
        .item_len (item_len),
        .lanes    (item_lane),
        .cur_bank (cur_bank),
        .cur_idx  (cur_idx),
        .cur_off  (cur_off),
        .rd_word  (rd_word)
    );

    // Register one response per access, one cycle after the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_err   <= 1'b0;
            resp_data  <= '0;
        end else begin
            resp_valid <= acc_valid;
            resp_err   <= acc_valid && (kind == ACC_REJECT);
            resp_data  <= rd_fire ? rd_word : '0;
        end
    end

    AST_RESP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> resp_valid); // R10
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !resp_valid); // R10
    AST_REJECT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        resp_err |-> (resp_data == '0)); // R8

endmodule

// File: tb/sim_cfg_item_port.sv
module sim_cfg_item_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        port_mode = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic        acc_sel = 1'b0;
    logic [2:0]  acc_offset = '0;
    logic [3:0]  acc_size = '0;
    logic [63:0] acc_wdata = '0;
    logic        resp_valid;
    logic        resp_err;
    logic [63:0] resp_data;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        logic        err;
        logic [63:0] data;
        string       tag;
    } exp_t;
    exp_t q[$];

    // reference model state
    logic [15:0] mkey = 16'h0000;
    bit          mvalid = 1;
    int          moff = 0;

    always #10 clk = ~clk;

    cfg_item_port u0 (
        .clk(clk), .rst_n(rst_n), .port_mode(port_mode),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_sel(acc_sel),
        .acc_offset(acc_offset), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .resp_valid(resp_valid), .resp_err(resp_err), .resp_data(resp_data)
    );

    function automatic int mlen(bit b, int i);
        return b ? (5 * i) % 17 : (3 * i + 4) % 17;
    endfunction

    function automatic logic [7:0] mbyte(bit b, int i, int o);
        return 8'((i * 16 + o + (b ? 128 : 0)) & 255);
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: computes the expected response, pushes it, drives the access
    task automatic acc(input bit wr, input bit sel, input logic [2:0] offs,
                       input logic [3:0] sz, input logic [63:0] wd, input string tag);
        exp_t e;
        int kindv; // 0 reject 1 select 2 read 3 drop
        kindv = 0;
        if (port_mode) begin
            if (sz == 1) kindv = wr ? 3 : 2;
            else if (sz == 2 && wr) kindv = 1;
        end else if (!sel) begin
            if (wr && sz == 2) kindv = 1;
        end else if (offs == 0 && sz >= 1 && sz <= 8) begin
            kindv = wr ? 3 : 2;
        end
        e.err = (kindv == 0);
        e.data = '0;
        e.tag = tag;
        if (kindv == 1) begin
            mkey = wd[15:0];
            mvalid = (int'(wd[14:0]) < 12);
            moff = 0;
        end else if (kindv == 2) begin
            bit b;
            int i, l, n;
            b = mkey[15];
            i = int'(mkey[14:0]);
            l = mvalid ? mlen(b, i) : 0;
            if (mvalid && moff < l) begin
                n = (int'(sz) < l - moff) ? int'(sz) : l - moff;
                for (int k = 0; k < n; k++)
                    e.data = e.data | (64'(mbyte(b, i, moff + k)) << (8 * (int'(sz) - 1 - k)));
                moff = moff + n;
            end
        end
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_sel = sel;
        acc_offset = offs; acc_size = sz; acc_wdata = wd;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        acc_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic sel_key(input logic [15:0] k, input string tag);
        if (port_mode) acc(1, 0, 0, 2, {48'h0, k}, tag);
        else           acc(1, 0, 0, 2, {48'h0, k}, tag);
    endtask

    task automatic rd(input logic [3:0] sz, input string tag);
        acc(0, 1, 0, sz, 64'h0, tag);
    endtask

    // monitor: pops and compares each response away from the clock edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (rst_n) begin
                if (resp_valid) begin
                    if (q.size() == 0) begin
                        check("R10 spurious response", 64'(resp_valid), 64'h0);
                    end else begin
                        exp_t e;
                        e = q.pop_front();
                        check({e.tag, " err"}, 64'(resp_err), 64'(e.err));
                        check({e.tag, " data"}, resp_data, e.data);
                    end
                end else if (q.size() != 0) begin
                    exp_t e;
                    e = q.pop_front();
                    check({e.tag, " R10 missing response"}, 64'(resp_valid), 64'h1);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 reset resp_valid", 64'(resp_valid), 64'h0);
        check("R1 reset resp_data", resp_data, 64'h0);

        // R1: signature item straight after reset (split framing)
        rd(4, "R1 first read");
        // R4 / R5 / R6: item 3 (length 13) read in several widths
        sel_key(16'h0003, "R2 select 3");
        rd(1, "R4 read1");
        rd(2, "R4 read2");
        rd(3, "R4 read3");
        rd(8, "R5 read past end padded");
        rd(2, "R6 read at end");
        // R2: reselect same key restarts
        sel_key(16'h0003, "R2 reselect");
        rd(4, "R2 restart read");
        // R3: local bank item 2 (length 10)
        sel_key(16'h8002, "R3 select local");
        rd(8, "R3 local read8");
        rd(4, "R5 local tail pad");
        sel_key(16'h000C, "R3 select out of range");
        rd(8, "R3 invalid read");
        sel_key(16'h800C, "R3 select local out of range");
        rd(2, "R6 invalid read local");
        sel_key(16'h8000, "R3 select local empty");
        rd(8, "R6 empty read");
        sel_key(16'h000A, "R3 select common empty");
        rd(1, "R6 empty common");
        idle(2);

        // R9: dropped data write leaves cursor alone
        sel_key(16'h0001, "R9 select 1");
        rd(2, "R9 read before");
        acc(1, 1, 0, 4, 64'hDEAD_BEEF_0000_0000, "R9 data write");
        rd(2, "R9 read after");
        // R8: split framing violations
        acc(0, 0, 0, 2, 64'h0, "R8 ctl read rejected");
        acc(1, 0, 0, 1, 64'h0005, "R8 ctl byte write rejected");
        acc(1, 0, 0, 4, 64'h0005, "R8 ctl wide write rejected");
        acc(0, 1, 3, 1, 64'h0, "R8 data offset rejected");
        acc(0, 1, 0, 0, 64'h0, "R8 size0 rejected");
        acc(0, 1, 0, 9, 64'h0, "R8 size9 rejected");
        rd(3, "R8 cursor untouched");
        idle(1);

        // R7: single-register framing
        port_mode = 1'b1;
        sel_key(16'h0004, "R7 select 4");
        rd(1, "R7 byte read a");
        rd(1, "R7 byte read b");
        acc(0, 0, 0, 4, 64'h0, "R7 wide read rejected");
        acc(0, 0, 0, 2, 64'h0, "R7 word read rejected");
        acc(1, 0, 0, 4, 64'h0002, "R7 wide write rejected");
        acc(1, 0, 0, 1, 64'h00FF, "R9 byte write dropped");
        rd(1, "R7 byte read c");
        acc(1, 0, 5, 2, 64'h8003, "R7 select local 3");
        rd(1, "R7 local byte");
        idle(1);

        // R11: sweep of both banks and two indices past the end
        port_mode = 1'b0;
        for (int b = 0; b < 2; b++) begin
            for (int i = 0; i < 14; i++) begin
                sel_key(16'((b << 15) | i), "R11 sweep select");
                rd(8, "R11 sweep read8 a");
                rd(8, "R11 sweep read8 b");
                rd(3, "R11 sweep read3");
            end
        end
        idle(4);

        check("R10 queue drained", 64'(q.size()), 64'h0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule